// File: doc/BRIEF.md
# Constant-Step Point Rotator

This block turns a point (x, y) about the z axis through a chain of angles that grow by one fixed step. It keeps the cosine and sine of the current angle in two coefficient registers. Each rotated point is formed directly from these two values. There is no chain of shift-add micro-rotations, so the result needs no gain correction.

A host supplies the cosine and sine of the step and picks one of two operations per start strobe. A rotate operation multiplies the stored cosine and sine into a fresh input point. An advance operation moves the stored angle on by one step using the angle-sum identities. The results are written back into the coefficient registers for the next rotation. Every rotation starts from the caller's original point, so rounding error in the coordinates never feeds into later steps. Only the coefficient pair carries error forward. The z coordinate travels alongside the operation unchanged.

The four products are built bit-serially, most significant multiplier bit first, in four accumulating multiply units. The final sum and difference come from either two dedicated add/sub units or one shared unit.

Top module: `step_rotator`

## Requirements
- R1: With `mode_i`=0 (rotate), `x_o` becomes the low N bits of round((x·C − y·S)/2^(N−1)) and `y_o` the low N bits of round((y·C + x·S)/2^(N−1)). Here C and S are the stored coefficients in two's complement with N−1 fraction bits, and round adds 2^(N−2) before an arithmetic right shift. Outputs change only on the cycle `done_o` is high.
- R2: With `mode_i`=1 (advance), the coefficients become C' = round((C·Cs − S·Ss)/2^(N−1)) and S' = round((S·Cs + C·Ss)/2^(N−1)). Cs and Ss are `cos_step_i` and `sin_step_i`, each N+1 bits wide with N−1 fraction bits.
- R3: After reset, the first accepted start loads C and S from the step inputs before it operates. A rotate issued straight after reset therefore turns the point by one step.
- R4: A rotate leaves C and S unchanged, so back-to-back rotates use the same angle and each acts on its own input point.
- R5: On a rotate, `z_o` takes the value `z_i` had at the accepted start, together with the new x and y.
- R6: An advance still pulses `done_o` but leaves `x_o`, `y_o` and `z_o` unchanged.
- R7: `done_o` is low out of reset. It is high for exactly one cycle, on the (N+2)-th rising edge after the edge that accepts the start, or the (N+3)-th when `SHARED_ADDSUB`=1.
- R8: A start raised while an operation is in flight is ignored. The running result is unaffected and no extra `done_o` follows.
- R9: The test runs 90 rotations at 4° per step, each followed by an advance. Every rotated coordinate stays within 24 LSB of the real-valued product of the point with the exact powers of the rounded step coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only when idle |
| mode_i | input | 1 | 0 rotate point, 1 advance angle |
| x_i | input | N | Point x, signed |
| y_i | input | N | Point y, signed |
| z_i | input | N | Point z, passed through |
| cos_step_i | input | N+1 | Cosine of the step, signed, N−1 fraction bits |
| sin_step_i | input | N+1 | Sine of the step, signed, N−1 fraction bits |
| x_o | output | N | Rotated x |
| y_o | output | N | Rotated y |
| z_o | output | N | z of the last rotated point |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with N=16 and two dedicated add/sub units, so one operation occupies 18 edges from the accepting edge. At this width, full-scale operands such as −32768 meet coefficients of exactly ±1.0. This exposes the 17-bit coefficient range and the wrap of a result of +32768 back to −32768. It also lets a full 360° walk in 4° steps show the drift of the coefficient pair against a real-valued model. Two 90° and 180° cases after a second reset give exact, hand-checkable results.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_FIN  = 2'd2
  } rot_state_e;
endpackage

// File: rtl/rot_serial_mac.sv
// Bit-serial signed multiply, multiplier MSB first (Horner form).
module rot_serial_mac #(
  parameter int CW = 17,
  localparam int AW = 2 * CW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 first_i,
  input  logic                 bit_i,
  input  logic signed [CW-1:0] coef_i,
  output logic signed [AW-1:0] acc_o
);
  logic signed [AW-1:0] coef_x;
  assign coef_x = AW'(coef_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
    end else if (en_i) begin
      if (first_i) acc_o <= bit_i ? -coef_x : '0;  // sign bit weighs negative
      else         acc_o <= (acc_o <<< 1) + (bit_i ? coef_x : '0);
    end
  end
endmodule

// File: rtl/rot_addsub.sv
// Add or subtract two products, round to nearest, drop N-1 fraction bits.
module rot_addsub #(
  parameter int N  = 16,
  localparam int CW = N + 1,
  localparam int AW = 2 * CW,
  localparam int SW = AW + 1
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] b_i,
  input  logic                 sub_i,
  output logic signed [CW-1:0] res_o
);
  logic signed [SW-1:0] sum, rnd;
  always_comb begin
    sum   = sub_i ? (SW'(a_i) - SW'(b_i)) : (SW'(a_i) + SW'(b_i));
    rnd   = sum + (SW'(1) <<< (N - 2));
    res_o = rnd[N-1 +: CW];
  end
endmodule

// File: rtl/step_rotator.sv
module step_rotator import rot_pkg::*; #(
  parameter int N             = 16,
  parameter bit SHARED_ADDSUB = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic signed [N-1:0] x_i,
  input  logic signed [N-1:0] y_i,
  input  logic signed [N-1:0] z_i,
  input  logic signed [N:0]   cos_step_i,
  input  logic signed [N:0]   sin_step_i,
  output logic signed [N-1:0] x_o,
  output logic signed [N-1:0] y_o,
  output logic signed [N-1:0] z_o,
  output logic                done_o
);
  localparam int CW   = N + 1;
  localparam int AW   = 2 * CW;
  localparam int CNTW = $clog2(CW);

  rot_state_e          state_q;
  logic [CNTW-1:0]     cnt_q;
  logic                upd_q, fresh_q;
  logic signed [N-1:0] z_hold_q;
  logic [CW-1:0]       sa_q, sb_q;
  logic signed [CW-1:0] c_q, s_q;
  logic signed [CW-1:0] r0, r1;
  logic                fin_ready;

  // product units: 0 sa*C, 1 sb*S, 2 sb*C, 3 sa*S
  logic [3:0]           mbit;
  logic signed [CW-1:0] mcoef [4];
  logic signed [AW-1:0] macc  [4];

  assign mbit     = {sa_q[CW-1], sb_q[CW-1], sb_q[CW-1], sa_q[CW-1]};
  assign mcoef[0] = c_q;
  assign mcoef[1] = s_q;
  assign mcoef[2] = c_q;
  assign mcoef[3] = s_q;

  for (genvar g = 0; g < 4; g++) begin : g_mac
    rot_serial_mac #(.CW(CW)) u_mac (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (state_q == ST_MAC),
      .first_i(cnt_q == '0),
      .bit_i  (mbit[g]),
      .coef_i (mcoef[g]),
      .acc_o  (macc[g])
    );
  end

  if (SHARED_ADDSUB) begin : g_shared
    logic                 phase_q;
    logic signed [CW-1:0] hold_q, res;
    rot_addsub #(.N(N)) u_as (
      .a_i  (phase_q ? macc[2] : macc[0]),
      .b_i  (phase_q ? macc[3] : macc[1]),
      .sub_i(!phase_q),
      .res_o(res)
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        phase_q <= 1'b0;
        hold_q  <= '0;
      end else if (state_q == ST_FIN) begin
        phase_q <= !phase_q;
        if (!phase_q) hold_q <= res;
      end
    end
    assign r0        = hold_q;
    assign r1        = res;
    assign fin_ready = (state_q == ST_FIN) && phase_q;
  end else begin : g_dual
    rot_addsub #(.N(N)) u_sub (
      .a_i(macc[0]), .b_i(macc[1]), .sub_i(1'b1), .res_o(r0)
    );
    rot_addsub #(.N(N)) u_add (
      .a_i(macc[2]), .b_i(macc[3]), .sub_i(1'b0), .res_o(r1)
    );
    assign fin_ready = (state_q == ST_FIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      upd_q    <= 1'b0;
      fresh_q  <= 1'b1;
      z_hold_q <= '0;
      sa_q     <= '0;
      sb_q     <= '0;
      c_q      <= '0;
      s_q      <= '0;
      x_o      <= '0;
      y_o      <= '0;
      z_o      <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          upd_q    <= mode_i;
          z_hold_q <= z_i;
          sa_q     <= mode_i ? cos_step_i : CW'(x_i);
          sb_q     <= mode_i ? sin_step_i : CW'(y_i);
          cnt_q    <= '0;
          state_q  <= ST_MAC;
          if (fresh_q) begin  // first use after reset starts at one step
            c_q     <= cos_step_i;
            s_q     <= sin_step_i;
            fresh_q <= 1'b0;
          end
        end
        ST_MAC: begin
          sa_q  <= {sa_q[CW-2:0], 1'b0};
          sb_q  <= {sb_q[CW-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNTW'(CW - 1)) state_q <= ST_FIN;
        end
        ST_FIN: if (fin_ready) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          if (upd_q) begin
            c_q <= r0;
            s_q <= r1;
          end else begin
            x_o <= r0[N-1:0];
            y_o <= r1[N-1:0];
            z_o <= z_hold_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/step_rotator_chk.sv
module step_rotator_chk #(
  parameter int N      = 16,
  parameter bit SHARED = 1'b0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                mode_i,
  input logic                idle_i,
  input logic signed [N-1:0] z_i,
  input logic signed [N-1:0] x_o,
  input logic signed [N-1:0] y_o,
  input logic signed [N-1:0] z_o,
  input logic                done_o
);
  localparam int LAT = N + 2 + int'(SHARED);
  localparam int AGW = $clog2(N + 8) + 1;

  logic [AGW-1:0]      age_q;
  logic                upd_c;
  logic signed [N-1:0] z_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      upd_c <= 1'b0;
      z_c   <= '0;
    end else if (start_i && idle_i) begin
      age_q <= AGW'(1);
      upd_c <= mode_i;
      z_c   <= z_i;
    end else if (done_o) begin
      age_q <= '0;
    end else if (age_q != '0) begin
      age_q <= age_q + 1'b1;
    end
  end

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> age_q == AGW'(LAT + 1));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(x_o) && $stable(y_o) && $stable(z_o));
  p_advance_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && upd_c |-> $stable(x_o) && $stable(y_o) && $stable(z_o));
  p_z_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !upd_c |-> z_o == z_c);
  p_busy_owned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> age_q != '0);
endmodule

bind step_rotator step_rotator_chk #(.N(N), .SHARED(SHARED_ADDSUB)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .mode_i (mode_i),
  .idle_i (state_q == rot_pkg::ST_IDLE),
  .z_i    (z_i),
  .x_o    (x_o),
  .y_o    (y_o),
  .z_o    (z_o),
  .done_o (done_o)
);

// File: tb/step_rotator_tb.sv
`timescale 1ns/1ps
module step_rotator_tb;
  localparam int  N     = 16;
  localparam int  LAT   = N + 2;
  localparam int  NSTEP = 90;
  localparam real TOL   = 24.0;
  localparam real PI    = 3.14159265358979;
  localparam logic signed [15:0] PTS [8][2] = '{
    '{16'sd16384, 16'sd0}, '{-16'sd12000, 16'sd9000}, '{16'sd0, -16'sd20000},
    '{16'sd14000, 16'sd14000}, '{-16'sd7, 16'sd3}, '{16'sd19999, -16'sd1},
    '{-16'sd15000, -16'sd11000}, '{16'sd5000, 16'sd18000}};

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mode_i = 1'b0, done_o;
  logic signed [N-1:0] x_i = '0, y_i = '0, z_i = '0, x_o, y_o, z_o;
  logic signed [N:0]   cos_step_i = '0, sin_step_i = '0;

  always #2.5 clk = ~clk;

  step_rotator #(.N(N), .SHARED_ADDSUB(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .z_i(z_i), .cos_step_i(cos_step_i),
    .sin_step_i(sin_step_i), .x_o(x_o), .y_o(y_o), .z_o(z_o), .done_o(done_o));

  int     checks = 0, fails = 0;
  longint cd, sd, c_m, s_m;
  real    cdr, sdr, cr, sr;

  function automatic longint rnd15(longint v);
    return (v + 64'sd16384) >>> 15;
  endfunction
  function automatic longint wrap16(longint v);
    logic signed [15:0] t;
    t = 16'(v);
    return longint'(t);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    c_m = cd; s_m = sd; cr = cdr; sr = sdr;
  endtask

  task automatic run_op(input bit m, input longint x, input longint y, input longint z,
                        input bit poke, input longint px, input longint py, output int lat);
    @(negedge clk);
    mode_i = m; x_i = 16'(x); y_i = 16'(y); z_i = 16'(z); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 3) begin
        start_i = 1'b1; mode_i = 1'b0; x_i = 16'(px); y_i = 16'(py);
      end else start_i = 1'b0;
    end
    if (lat >= 200) chk("R7 op watchdog", lat, LAT);
  endtask

  task automatic pulse_low();
    @(negedge clk);
    chk("R7 done one cycle", longint'(done_o), 0);
  endtask

  task automatic rotate_check(input longint x, input longint y, input longint z,
                              input string tag, input bit rbound, input bit poke,
                              input longint px, input longint py);
    longint ex, ey;
    int lat;
    real rx, ry, e;
    ex = wrap16(rnd15(x * c_m - y * s_m));
    ey = wrap16(rnd15(y * c_m + x * s_m));
    run_op(1'b0, x, y, z, poke, px, py, lat);
    chk({tag, " x"}, longint'(x_o), ex);
    chk({tag, " y"}, longint'(y_o), ey);
    chk("R5 z", longint'(z_o), z);
    chk("R7 latency", lat, LAT);
    if (rbound) begin
      rx = real'(x) * cr - real'(y) * sr;
      ry = real'(y) * cr + real'(x) * sr;
      e = real'(x_o) - rx; if (e < 0.0) e = -e;
      checks++;
      if (e > TOL) begin fails++; $display("FAIL R9 x actual=%0d expected=%0f", x_o, rx); end
      e = real'(y_o) - ry; if (e < 0.0) e = -e;
      checks++;
      if (e > TOL) begin fails++; $display("FAIL R9 y actual=%0d expected=%0f", y_o, ry); end
    end
    pulse_low();
  endtask

  task automatic advance_check();
    longint px, py, pz, nc, ns;
    int lat;
    real ncr;
    px = longint'(x_o); py = longint'(y_o); pz = longint'(z_o);
    run_op(1'b1, 123, -456, 789, 1'b0, 0, 0, lat);
    chk("R6 x kept", longint'(x_o), px);
    chk("R6 y kept", longint'(y_o), py);
    chk("R6 z kept", longint'(z_o), pz);
    chk("R7 latency", lat, LAT);
    pulse_low();
    nc  = rnd15(c_m * cd - s_m * sd);
    ns  = rnd15(s_m * cd + c_m * sd);
    c_m = nc; s_m = ns;
    ncr = cr * cdr - sr * sdr;
    sr  = sr * cdr + cr * sdr;
    cr  = ncr;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cd = longint'($rtoi(32768.0 * $cos(4.0 * PI / 180.0) + 0.5));
    sd = longint'($rtoi(32768.0 * $sin(4.0 * PI / 180.0) + 0.5));
    cdr = real'(cd) / 32768.0; sdr = real'(sd) / 32768.0;
    cos_step_i = 17'(cd); sin_step_i = 17'(sd);
    repeat (3) @(negedge clk);
    chk("R7 reset done", longint'(done_o), 0);
    chk("R1 reset x", longint'(x_o), 0);
    chk("R1 reset y", longint'(y_o), 0);
    chk("R5 reset z", longint'(z_o), 0);
    rst_ni = 1'b1;
    model_reset();

    // 90 steps of 4 degrees, table walked in a loop
    for (int k = 0; k < NSTEP; k++) begin
      rotate_check(PTS[k % 8][0], PTS[k % 8][1], longint'(k * 37 - 1000),
                   (k == 0) ? "R3 first" : "R2 rot", 1'b1, 1'b0, 0, 0);
      if (k % 15 == 0)
        rotate_check(PTS[(k + 3) % 8][0], PTS[(k + 3) % 8][1], 55, "R4 same angle",
                     1'b1, 1'b0, 0, 0);
      advance_check();
    end

    // R8: start during busy is ignored
    rotate_check(9000, -4000, 321, "R8 busy", 1'b0, 1'b1, -20000, 20000);
    repeat (LAT + 8) begin
      @(negedge clk);
      chk("R8 no extra done", longint'(done_o), 0);
    end

    // R3: reset reloads from the step inputs (90 degree step)
    @(negedge clk);
    rst_ni = 1'b0;
    cd = 0; sd = 32768; cdr = 0.0; sdr = 1.0;
    cos_step_i = 17'(cd); sin_step_i = 17'(sd);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    rotate_check(1000, 2000, 7, "R3 reload", 1'b0, 1'b0, 0, 0);
    chk("R3 literal x", longint'(x_o), -2000);
    chk("R3 literal y", longint'(y_o), 1000);
    rotate_check(-300, 50, 8, "R4 repeat", 1'b0, 1'b0, 0, 0);
    advance_check();
    chk("R2 cos at 180", c_m, -32768);
    rotate_check(1000, 2000, 9, "R2 half turn", 1'b0, 1'b0, 0, 0);
    chk("R2 literal x", longint'(x_o), -1000);
    rotate_check(-32768, -32767, -1, "R1 wrap", 1'b0, 1'b0, 0, 0);
    chk("R1 wrap literal x", longint'(x_o), -32768);
    chk("R1 wrap literal y", longint'(y_o), 32767);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule